// File: doc/BRIEF.md
# Block Copy and Block Search Step Engine

This block carries out one step of an 8-bit processor's block memory instructions. Each step either copies one byte from a source pointer to a destination pointer or compares one byte at the source pointer with the accumulator. The surrounding core supplies the register values and the operation class: copy or compare, pointers stepping up or down, single or repeating. The engine performs the memory read, and for a copy also the write. It returns the stepped pointers, the decremented 16-bit count and the new flag byte.

Each step ends with a one-cycle `done` pulse. Along with it come a `rewind` flag, which tells the core to set the program counter back to the instruction's own address and run it again, and a count of extra internal cycles that the core adds to its timing. The X and Y flag bits follow the undocumented derivation from intermediate sums. The repeating copy and the repeating compare stop under different rules.

Top module: `blkx_engine`

## Requirements
- R1: After synchronous reset, `done`, `rewind`, `busy`, `mem_rd` and `mem_wr` are 0, and `src_out`, `dst_out`, `cnt_out`, `flags_out` and `extra_cyc` are 0.
- R2: In every step, the engine asserts `mem_rd` for one cycle with `mem_addr` equal to the source pointer. In a copy step only, it then asserts `mem_wr` for one cycle (the `done` cycle), with `mem_addr` equal to the destination pointer and `mem_wdata` equal to the byte that was read. A compare step never writes.
- R3: The source pointer steps by +1 when `op_dec`=0 and by -1 when `op_dec`=1, modulo 2^16. The destination pointer steps the same way in a copy step and stays unchanged in a compare step.
- R4: `cnt_out` equals `cnt_in` minus 1, modulo 2^16, so a count of 0 becomes 0xFFFF.
- R5: In the flag byte, bit 7 is S, bit 6 is Z, bit 5 is Y, bit 4 is H, bit 3 is X, bit 2 is P/V, bit 1 is N and bit 0 is C. After a copy step, H=0 and N=0, P/V=1 exactly when the new count is nonzero, and S, Z and C keep their values from `flags_in`.
- R6: After a copy step, X (bit 3) equals bit 3 and Y (bit 5) equals bit 1 of the 8-bit sum of the copied byte and the accumulator.
- R7: After a compare step with d = acc - m (8 bits): S = d[7], Z = (d == 0), H = 1 when acc[3:0] < m[3:0] (a borrow out of the low nibble), N = 1, P/V = 1 exactly when the new count is nonzero, and C keeps its value from `flags_in`.
- R8: After a compare step, X (bit 3) equals bit 3 and Y (bit 5) equals bit 1 of the 8-bit value acc - m - H.
- R9: A repeating copy (`op_rep`=1, `op_cmp`=0) raises `rewind` exactly when the new count is nonzero.
- R10: A repeating compare (`op_rep`=1, `op_cmp`=1) raises `rewind` exactly when the new count is nonzero and d is nonzero. A single (`op_rep`=0) step never raises `rewind`.
- R11: `extra_cyc` is 5 in the `done` cycle when `rewind` is 1, and 0 otherwise.
- R12: A start sampled while idle produces a one-cycle `done` pulse three clock edges later. `busy` is 1 from the edge that accepts the start until `done`, and a `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one step (accepted only while idle) |
| op_cmp | input | 1 | 1 = compare step, 0 = copy step |
| op_dec | input | 1 | 1 = pointers step down, 0 = up |
| op_rep | input | 1 | 1 = repeating form |
| src_in | input | 16 | Source pointer |
| dst_in | input | 16 | Destination pointer |
| cnt_in | input | 16 | Byte count |
| acc_in | input | 8 | Accumulator |
| flags_in | input | 8 | Current flag byte |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request is sampled |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | 8 | Memory write data |
| src_out | output | 16 | Stepped source pointer |
| dst_out | output | 16 | Stepped destination pointer |
| cnt_out | output | 16 | Decremented count |
| flags_out | output | 8 | New flag byte |
| done | output | 1 | Step complete (one cycle) |
| rewind | output | 1 | Core must rerun the instruction |
| extra_cyc | output | 3 | Extra internal cycles to add |
| busy | output | 1 | Step in progress |

## Verification
On every cycle, the assertions check the following. The `done` pulse lasts one cycle and follows its read two cycles earlier. A read and a write are never requested together. The extra cycle count agrees with `rewind`. A rewind never happens on a zero count. P/V always tracks the count. Only the bench scenarios can show the exact flag arithmetic, the byte actually written to memory, the pointer direction and wrap, the different stop rules of copy and compare, and that a start while busy has no effect. The bench computes each of these from the register inputs it chose.

// File: rtl/blkx_pkg.sv
`timescale 1ns/1ps
package blkx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_DATA = 2'd2
  } blkx_state_e;

  typedef struct packed {
    logic cmp;
    logic dec;
    logic rep;
  } blkx_op_t;

  // flag byte bit positions (decoded by the surrounding core)
  localparam int FB_S = 7;
  localparam int FB_Z = 6;
  localparam int FB_Y = 5;
  localparam int FB_H = 4;
  localparam int FB_X = 3;
  localparam int FB_P = 2;
  localparam int FB_N = 1;
  localparam int FB_C = 0;
endpackage

// File: rtl/blkx_ptr_step.sv
`timescale 1ns/1ps
module blkx_ptr_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] ptr_i,
  input  logic         en_i,
  input  logic         dec_i,
  output logic [W-1:0] ptr_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (!en_i)     ptr_o = ptr_i;
    else if (dec_i) ptr_o = ptr_i - ONE;
    else           ptr_o = ptr_i + ONE;
  end
endmodule

// File: rtl/blkx_flag_calc.sv
`timescale 1ns/1ps
module blkx_flag_calc
  import blkx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          is_cmp_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mbyte_i,
  input  logic [7:0]    flags_i,
  input  logic          cnt_nz_i,
  output logic [7:0]    flags_o,
  output logic          diff_zero_o
);
  logic [DW-1:0] sum_v;
  logic [DW-1:0] diff_v;
  logic [DW-1:0] xy_v;
  logic          half_b;

  always_comb begin
    sum_v       = acc_i + mbyte_i;
    diff_v      = acc_i - mbyte_i;
    half_b      = (acc_i[3:0] < mbyte_i[3:0]);
    xy_v        = diff_v - DW'(half_b);
    diff_zero_o = (diff_v == '0);
    flags_o     = flags_i;
    if (is_cmp_i) begin
      flags_o[FB_S] = diff_v[DW-1];
      flags_o[FB_Z] = diff_zero_o;
      flags_o[FB_H] = half_b;
      flags_o[FB_N] = 1'b1;
      flags_o[FB_X] = xy_v[3];
      flags_o[FB_Y] = xy_v[1];
    end else begin
      flags_o[FB_H] = 1'b0;
      flags_o[FB_N] = 1'b0;
      flags_o[FB_X] = sum_v[3];
      flags_o[FB_Y] = sum_v[1];
    end
    flags_o[FB_P] = cnt_nz_i;
  end
endmodule

// File: rtl/blkx_ctrl.sv
`timescale 1ns/1ps
module blkx_ctrl
  import blkx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int EXTRA_CYC = 5,
  parameter int ECW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  blkx_op_t       op_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [7:0]     flags_i,
  input  logic [DW-1:0]  mem_rdata,
  // latched step context
  output blkx_op_t       lat_op,
  output logic [AW-1:0]  lat_src,
  output logic [AW-1:0]  lat_dst,
  output logic [CW-1:0]  lat_cnt,
  output logic [DW-1:0]  lat_acc,
  output logic [7:0]     lat_flags,
  // results from datapath
  input  logic [AW-1:0]  nxt_src,
  input  logic [AW-1:0]  nxt_dst,
  input  logic [CW-1:0]  nxt_cnt,
  input  logic [7:0]     nxt_flags,
  input  logic           diff_zero,
  // registered outputs
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  output logic [AW-1:0]  src_o,
  output logic [AW-1:0]  dst_o,
  output logic [CW-1:0]  cnt_o,
  output logic [7:0]     flags_o,
  output logic           done_o,
  output logic           rewind_o,
  output logic [ECW-1:0] extra_o,
  output logic           busy_o
);
  blkx_state_e state_q;
  logic        cnt_nz;
  logic        again;

  always_comb begin
    cnt_nz = (nxt_cnt != '0);
    again  = lat_op.rep & cnt_nz & (~lat_op.cmp | ~diff_zero);
    busy_o = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      lat_op    <= '0;
      lat_src   <= '0;
      lat_dst   <= '0;
      lat_cnt   <= '0;
      lat_acc   <= '0;
      lat_flags <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      src_o     <= '0;
      dst_o     <= '0;
      cnt_o     <= '0;
      flags_o   <= '0;
      done_o    <= 1'b0;
      rewind_o  <= 1'b0;
      extra_o   <= '0;
    end else begin
      done_o <= 1'b0;
      mem_wr <= 1'b0;
      mem_rd <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            lat_op    <= op_i;
            lat_src   <= src_i;
            lat_dst   <= dst_i;
            lat_cnt   <= cnt_i;
            lat_acc   <= acc_i;
            lat_flags <= flags_i;
            mem_addr  <= src_i;
            mem_rd    <= 1'b1;
            state_q   <= ST_READ;
          end
        end
        ST_READ: begin
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          src_o     <= nxt_src;
          dst_o     <= nxt_dst;
          cnt_o     <= nxt_cnt;
          flags_o   <= nxt_flags;
          rewind_o  <= again;
          extra_o   <= again ? ECW'(EXTRA_CYC) : '0;
          done_o    <= 1'b1;
          mem_wr    <= ~lat_op.cmp;
          mem_addr  <= lat_dst;
          mem_wdata <= mem_rdata;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkx_engine.sv
`timescale 1ns/1ps
module blkx_engine
  import blkx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int EXTRA_CYC = 5,
  localparam int ECW = $clog2(EXTRA_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           op_cmp,
  input  logic           op_dec,
  input  logic           op_rep,
  input  logic [AW-1:0]  src_in,
  input  logic [AW-1:0]  dst_in,
  input  logic [CW-1:0]  cnt_in,
  input  logic [DW-1:0]  acc_in,
  input  logic [7:0]     flags_in,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  output logic [AW-1:0]  src_out,
  output logic [AW-1:0]  dst_out,
  output logic [CW-1:0]  cnt_out,
  output logic [7:0]     flags_out,
  output logic           done,
  output logic           rewind,
  output logic [ECW-1:0] extra_cyc,
  output logic           busy
);
  blkx_op_t      op_in;
  blkx_op_t      lat_op;
  logic [AW-1:0] lat_src, lat_dst, nxt_src, nxt_dst;
  logic [CW-1:0] lat_cnt, nxt_cnt;
  logic [DW-1:0] lat_acc;
  logic [7:0]    lat_flags, nxt_flags;
  logic          diff_zero;

  always_comb begin
    op_in     = '{cmp: op_cmp, dec: op_dec, rep: op_rep};
    nxt_cnt   = lat_cnt - CW'(1);
  end

  blkx_ctrl #(
    .AW(AW), .DW(DW), .CW(CW), .EXTRA_CYC(EXTRA_CYC), .ECW(ECW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_i(op_in),
    .src_i(src_in), .dst_i(dst_in), .cnt_i(cnt_in), .acc_i(acc_in),
    .flags_i(flags_in), .mem_rdata(mem_rdata),
    .lat_op(lat_op), .lat_src(lat_src), .lat_dst(lat_dst), .lat_cnt(lat_cnt),
    .lat_acc(lat_acc), .lat_flags(lat_flags),
    .nxt_src(nxt_src), .nxt_dst(nxt_dst), .nxt_cnt(nxt_cnt),
    .nxt_flags(nxt_flags), .diff_zero(diff_zero),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .src_o(src_out), .dst_o(dst_out), .cnt_o(cnt_out), .flags_o(flags_out),
    .done_o(done), .rewind_o(rewind), .extra_o(extra_cyc), .busy_o(busy)
  );

  // source always steps; destination only for copies
  blkx_ptr_step #(.W(AW)) u_src_step (
    .ptr_i(lat_src), .en_i(1'b1), .dec_i(lat_op.dec), .ptr_o(nxt_src)
  );

  blkx_ptr_step #(.W(AW)) u_dst_step (
    .ptr_i(lat_dst), .en_i(~lat_op.cmp), .dec_i(lat_op.dec), .ptr_o(nxt_dst)
  );

  blkx_flag_calc #(.DW(DW)) u_flags (
    .is_cmp_i(lat_op.cmp), .acc_i(lat_acc), .mbyte_i(mem_rdata),
    .flags_i(lat_flags), .cnt_nz_i(nxt_cnt != '0),
    .flags_o(nxt_flags), .diff_zero_o(diff_zero)
  );
endmodule

// File: rtl/blkx_checker.sv
`timescale 1ns/1ps
module blkx_checker #(
  parameter int CW = 16,
  parameter int EXTRA_CYC = 5,
  parameter int ECW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           done,
  input logic           rewind,
  input logic [ECW-1:0] extra_cyc,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [7:0]     flags_out,
  input logic [CW-1:0]  cnt_out,
  input logic           busy
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R12
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (rst) done |-> $past(mem_rd, 2)); // R12
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R2
  AST_WR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst) mem_wr |-> done); // R2
  AST_EXTRA_MATCH: assert property (@(posedge clk) disable iff (rst)
    done |-> (extra_cyc == (rewind ? ECW'(EXTRA_CYC) : '0))); // R11
  AST_NO_REWIND_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && rewind) |-> (cnt_out != '0)); // R9
  AST_PARITY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags_out[2] == (cnt_out != '0))); // R5
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R12
endmodule

bind blkx_engine blkx_checker #(.CW(CW), .EXTRA_CYC(EXTRA_CYC), .ECW(ECW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .rewind(rewind), .extra_cyc(extra_cyc),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .flags_out(flags_out), .cnt_out(cnt_out),
  .busy(busy)
);

// File: tb/sim_blkx_engine.sv
`timescale 1ns/1ps
module sim_blkx_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_cmp = 1'b0, op_dec = 1'b0, op_rep = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic [7:0]  acc_in = '0, flags_in = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, src_out, dst_out, cnt_out;
  logic        mem_rd, mem_wr, done, rewind, busy;
  logic [7:0]  mem_wdata, flags_out;
  logic [2:0]  extra_cyc;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mem [256];

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  blkx_engine u0 (
    .clk(clk), .rst(rst), .start(start), .op_cmp(op_cmp), .op_dec(op_dec),
    .op_rep(op_rep), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
    .acc_in(acc_in), .flags_in(flags_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out), .flags_out(flags_out),
    .done(done), .rewind(rewind), .extra_cyc(extra_cyc), .busy(busy)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_flags(logic cmp, logic [7:0] a, logic [7:0] m,
                                           logic [7:0] fin, logic nz);
    logic [7:0] f, s, d, xy;
    logic h;
    if (!cmp) begin
      s = a + m;
      f = {fin[7], fin[6], s[1], 1'b0, s[3], nz, 1'b0, fin[0]};
    end else begin
      d  = a - m;
      h  = (a[3:0] < m[3:0]);
      xy = d - {7'd0, h};
      f  = {d[7], d == 8'd0, xy[1], h, xy[3], nz, 1'b1, fin[0]};
    end
    return f;
  endfunction

  // runs one step and checks every result at the done cycle
  task automatic step(string tag, logic cmp, logic dec, logic rep,
                      logic [15:0] s, logic [15:0] d, logic [15:0] c,
                      logic [7:0] a, logic [7:0] fin, logic [7:0] m,
                      logic busy_poke);
    logic [15:0] e_src, e_dst, e_cnt;
    logic [7:0]  e_flags, old_dst;
    logic        e_rew;
    int          waited;
    mem[s[7:0]] = m;
    old_dst = mem[d[7:0]];
    @(negedge clk);
    op_cmp = cmp; op_dec = dec; op_rep = rep;
    src_in = s; dst_in = d; cnt_in = c; acc_in = a; flags_in = fin;
    start = 1'b1;
    @(negedge clk);
    if (busy_poke) begin
      // R12: new start with other values while busy must be ignored
      op_cmp = ~cmp; src_in = s ^ 16'h0055; dst_in = d ^ 16'h0033;
      cnt_in = c ^ 16'h0F0F; acc_in = ~a; flags_in = ~fin;
      chk({tag, " R12 busy"}, busy, 1);
    end else begin
      start = 1'b0;
    end
    waited = 1;
    while (!done && waited < 10) begin
      @(negedge clk);
      waited++;
      if (waited == 2) start = 1'b0;
    end
    start = 1'b0;
    e_cnt   = c - 16'd1;
    e_src   = dec ? s - 16'd1 : s + 16'd1;
    e_dst   = cmp ? d : (dec ? d - 16'd1 : d + 16'd1);
    e_flags = ref_flags(cmp, a, m, fin, e_cnt != 16'd0);
    e_rew   = rep && (e_cnt != 16'd0) && (!cmp || (a != m));
    chk({tag, " R12 latency"}, waited, 3);
    chk({tag, " R3 src"}, src_out, e_src);
    chk({tag, " R3 dst"}, dst_out, e_dst);
    chk({tag, " R4 cnt"}, cnt_out, e_cnt);
    chk({tag, cmp ? " R7 R8 flags" : " R5 R6 flags"}, flags_out, e_flags);
    chk({tag, cmp ? " R10 rewind" : " R9 rewind"}, rewind, e_rew);
    chk({tag, " R11 extra"}, extra_cyc, e_rew ? 5 : 0);
    chk({tag, " R2 wr"}, mem_wr, !cmp);
    @(negedge clk);
    chk({tag, " R12 pulse"}, done, 0);
    chk({tag, " R2 dst byte"}, mem[d[7:0]], cmp ? old_dst : m);
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 mem_wr", mem_wr, 0);
    chk("R1 cnt", cnt_out, 0);
    chk("R1 flags", flags_out, 0);
    chk("R1 extra", extra_cyc, 0);
  endtask

  task automatic t_copy_up;        step("copy_up",  0, 0, 0, 16'h0010, 16'h0080, 16'h0004, 8'h0E, 8'hC1, 8'h3C, 0); endtask
  task automatic t_copy_down_rep;  step("copy_dn",  0, 1, 1, 16'h0020, 16'h0090, 16'h0003, 8'h01, 8'h00, 8'hA7, 0); endtask
  task automatic t_copy_last;      step("copy_end", 0, 0, 1, 16'h00FF, 16'h00A0, 16'h0001, 8'h55, 8'h40, 8'h12, 0); endtask
  task automatic t_cnt_wrap;       step("wrap",     0, 1, 1, 16'h0000, 16'h0000, 16'h0000, 8'h7F, 8'h81, 8'h01, 0); endtask
  task automatic t_cmp_match;      step("cmp_hit",  1, 0, 1, 16'h0030, 16'h00B0, 16'h0009, 8'h42, 8'h01, 8'h42, 0); endtask
  task automatic t_cmp_miss;       step("cmp_miss", 1, 1, 1, 16'h0040, 16'h00B1, 16'h0009, 8'h20, 8'h00, 8'h13, 0); endtask
  task automatic t_cmp_cnt_end;    step("cmp_cnt",  1, 0, 1, 16'h0050, 16'h00B2, 16'h0001, 8'h05, 8'h01, 8'h80, 0); endtask
  task automatic t_cmp_single;     step("cmp_one",  1, 0, 0, 16'h0060, 16'h00B3, 16'h0010, 8'h10, 8'h00, 8'h01, 0); endtask
  task automatic t_busy_ignore;    step("busy",     0, 0, 1, 16'h0070, 16'h00C0, 16'h0002, 8'h33, 8'h00, 8'h5A, 1); endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_copy_up();
    t_copy_down_rep();
    t_copy_last();
    t_cnt_wrap();
    t_cmp_match();
    t_cmp_miss();
    t_cmp_cnt_end();
    t_cmp_single();
    t_busy_ignore();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule